// File: doc/BRIEF.md
# TDM Serial Receive Framer

This block terminates four time-division multiplexed serial input lines that share one bit clock running at twice the line bit rate, so every bit cell spans two clock periods. A frame is 32 eight-bit channels long and each channel arrives most significant bit first. One slot counter tracks where the block is within the frame: channel, bit and the half of the bit cell. An active-low frame pulse, one clock wide, resynchronises that counter. The pulse is sampled on the clock edge that separates the last bit of channel 31 from the first bit of channel 0.

Each line is sampled once per bit cell, in the second half of the cell. When the last bit of a channel has been taken, the four received bytes are handed to a single write port for an external 128-location data memory, one stream per clock. The location is stream × 32 + channel. The counter position is also exported so that a transmit side can follow the same timeslot. After reset the counter runs freely from zero. Nothing is written to memory until a frame pulse has been seen.

Top module: `tdm_rx_framer`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, slot_chan_o is 0, slot_bit_o is 7, slot_half_o is 0 and mem_we_o is 0.
- R2: With frame_ni high, each clock toggles slot_half_o (0 = first half of the bit cell, 1 = second half). When slot_half_o is 1, slot_bit_o steps down by one, from 7 to 0. After the cycle with bit 0 in the second half, slot_bit_o returns to 7 and slot_chan_o increments, wrapping from 31 to 0. A full frame therefore takes 512 cycles.
- R3: A clock edge that samples frame_ni low puts the counter at channel 0, bit 7, first half in the following cycle, whatever its previous position.
- R4: Each rx_i line is sampled only on the edge that ends a cycle with slot_half_o = 1. The line level during the first half of a bit cell has no effect on the stored byte.
- R5: The bit sampled while slot_bit_o = k becomes bit k of the stored byte, so the first bit of a channel lands in bit 7.
- R6: After the edge that completes bit 0 of channel c, mem_we_o is 1 for exactly four consecutive cycles. In those cycles mem_addr_o is s*32+c, with the stream s in bits 6:5 taking the values 0, 1, 2, 3 in that order, and mem_wdata_o is the byte received on stream s. At all other times mem_we_o is 0.
- R7: From reset until the first edge that samples frame_ni low, mem_we_o stays 0. A channel that completes on that same edge is not written.
- R8: Once framed with one pulse per frame, each of the 128 locations is written exactly once in every 512-cycle window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock, two periods per serial bit |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_ni | input | 1 | Frame pulse, active low, one clock wide |
| rx_i | input | 4 | Serial input lines, one per stream |
| mem_we_o | output | 1 | Data memory write strobe |
| mem_addr_o | output | 7 | Data memory address, stream in bits 6:5, channel in bits 4:0 |
| mem_wdata_o | output | 8 | Received byte for the addressed location |
| slot_chan_o | output | 5 | Current channel number |
| slot_bit_o | output | 3 | Bit number currently being received, 7 down to 0 |
| slot_half_o | output | 1 | Half of the bit cell, 1 = second half |

## Verification
The assertions check the slot counter's stepping, its wrap and its realignment on every cycle. They also check that each write burst starts right after the last bit of a channel, runs through the four streams in order and stops, and that no write appears before the first frame pulse. The correctness of the byte contents only shows in the bench scenarios. So do the rejection of first-half line levels, the skipped commit on the first framing edge, mid-frame resynchronisation and the once-per-frame coverage of all 128 locations. The bench drives deliberately wrong levels in every first half cell and compares each written byte with the byte it sent.

// File: rtl/tdm_rx_pkg.sv
package tdm_rx_pkg;

    localparam int DEF_STREAMS = 4;
    localparam int DEF_CHANS   = 32;
    localparam int DEF_BITS    = 8;

    // Position of the clock period inside a bit cell
    typedef enum logic {
        HALF_EARLY = 1'b0,
        HALF_LATE  = 1'b1
    } half_e;

endpackage

// File: rtl/tdm_rx_timer.sv
module tdm_rx_timer
    import tdm_rx_pkg::*;
#(
    parameter int CHANS = DEF_CHANS,
    parameter int BITS  = DEF_BITS
) (
    input  logic                     clk_i,
    input  logic                     rst_ni,
    input  logic                     frame_ni,
    output logic [$clog2(CHANS)-1:0] chan_o,
    output logic [$clog2(BITS)-1:0]  bit_o,
    output logic                     half_o,
    output logic                     sample_o,
    output logic                     last_o,
    output logic                     locked_o
);
    localparam int CW = $clog2(CHANS);
    localparam int PW = $clog2(BITS);
    localparam int TW = CW + PW + 1;
    localparam logic [TW-1:0] LAST_CNT = TW'(CHANS * BITS * 2 - 1);
    localparam logic [PW-1:0] TOP_BIT  = PW'(BITS - 1);

    // cnt layout: [0] half cell, [PW:1] bit position from MSB, upper bits channel
    typedef struct packed {
        logic [TW-1:0] cnt;
        logic          locked;
    } tmr_t;

    tmr_t s_d, s_q;
    logic [PW-1:0] pos;

    always_comb begin
        s_d = s_q;
        if (!frame_ni) begin
            s_d.cnt    = '0;
            s_d.locked = 1'b1;
        end else if (s_q.cnt == LAST_CNT) begin
            s_d.cnt = '0;
        end else begin
            s_d.cnt = s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign pos      = s_q.cnt[PW:1];
    assign chan_o   = s_q.cnt[TW-1:PW+1];
    assign bit_o    = TOP_BIT - pos;
    assign half_o   = s_q.cnt[0];
    assign sample_o = (s_q.cnt[0] == HALF_LATE);
    assign last_o   = sample_o && (pos == TOP_BIT);
    assign locked_o = s_q.locked;

endmodule

// File: rtl/tdm_rx_deser.sv
module tdm_rx_deser
    import tdm_rx_pkg::*;
#(
    parameter int BITS = DEF_BITS
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            sample_i,
    input  logic            rx_i,
    output logic [BITS-1:0] byte_o
);
    // Only BITS-1 bits are stored; the final bit is merged on the fly
    logic [BITS-2:0] sh_d, sh_q;

    assign byte_o = {sh_q, rx_i};

    always_comb begin
        sh_d = sh_q;
        if (sample_i) begin
            sh_d = byte_o[BITS-2:0];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            sh_q <= '0;
        end else begin
            sh_q <= sh_d;
        end
    end

endmodule

// File: rtl/tdm_rx_writer.sv
module tdm_rx_writer
    import tdm_rx_pkg::*;
#(
    parameter int STREAMS = DEF_STREAMS,
    parameter int CHANS   = DEF_CHANS,
    parameter int BITS    = DEF_BITS
) (
    input  logic                                      clk_i,
    input  logic                                      rst_ni,
    input  logic                                      capture_i,
    input  logic [$clog2(CHANS)-1:0]                  chan_i,
    input  logic [STREAMS-1:0][BITS-1:0]              bytes_i,
    output logic                                      we_o,
    output logic [$clog2(STREAMS)+$clog2(CHANS)-1:0]  addr_o,
    output logic [BITS-1:0]                           wdata_o
);
    localparam int SW = $clog2(STREAMS);
    localparam int CW = $clog2(CHANS);
    localparam logic [SW-1:0] LAST_STRM = SW'(STREAMS - 1);

    typedef struct packed {
        logic [STREAMS-1:0][BITS-1:0] hold;
        logic [CW-1:0]                chan;
        logic [SW-1:0]                strm;
        logic                         busy;
    } wr_t;

    wr_t w_d, w_q;

    always_comb begin
        w_d = w_q;
        if (capture_i) begin
            w_d.hold = bytes_i;
            w_d.chan = chan_i;
            w_d.strm = '0;
            w_d.busy = 1'b1;
        end else if (w_q.busy) begin
            if (w_q.strm == LAST_STRM) begin
                w_d.busy = 1'b0;
            end else begin
                w_d.strm = w_q.strm + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            w_q <= '0;
        end else begin
            w_q <= w_d;
        end
    end

    assign we_o    = w_q.busy;
    assign addr_o  = {w_q.strm, w_q.chan};
    assign wdata_o = w_q.hold[w_q.strm];

endmodule

// File: rtl/tdm_rx_framer.sv
module tdm_rx_framer
    import tdm_rx_pkg::*;
#(
    parameter int STREAMS = DEF_STREAMS,
    parameter int CHANS   = DEF_CHANS,
    parameter int BITS    = DEF_BITS
) (
    input  logic                                      clk_i,
    input  logic                                      rst_ni,
    input  logic                                      frame_ni,
    input  logic [STREAMS-1:0]                        rx_i,
    output logic                                      mem_we_o,
    output logic [$clog2(STREAMS)+$clog2(CHANS)-1:0]  mem_addr_o,
    output logic [BITS-1:0]                           mem_wdata_o,
    output logic [$clog2(CHANS)-1:0]                  slot_chan_o,
    output logic [$clog2(BITS)-1:0]                   slot_bit_o,
    output logic                                      slot_half_o
);
    localparam int CW = $clog2(CHANS);

    logic                         sample;
    logic                         last_bit;
    logic                         locked;
    logic [CW-1:0]                chan;
    logic [STREAMS-1:0][BITS-1:0] bytes;

    tdm_rx_timer #(
        .CHANS (CHANS),
        .BITS  (BITS)
    ) i_timer (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .frame_ni (frame_ni),
        .chan_o   (chan),
        .bit_o    (slot_bit_o),
        .half_o   (slot_half_o),
        .sample_o (sample),
        .last_o   (last_bit),
        .locked_o (locked)
    );

    for (genvar s = 0; s < STREAMS; s++) begin : g_lane
        tdm_rx_deser #(
            .BITS (BITS)
        ) i_deser (
            .clk_i    (clk_i),
            .rst_ni   (rst_ni),
            .sample_i (sample),
            .rx_i     (rx_i[s]),
            .byte_o   (bytes[s])
        );
    end

    tdm_rx_writer #(
        .STREAMS (STREAMS),
        .CHANS   (CHANS),
        .BITS    (BITS)
    ) i_writer (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .capture_i (last_bit && locked),
        .chan_i    (chan),
        .bytes_i   (bytes),
        .we_o      (mem_we_o),
        .addr_o    (mem_addr_o),
        .wdata_o   (mem_wdata_o)
    );

    assign slot_chan_o = chan;

endmodule

// File: rtl/tdm_rx_framer_chk.sv
module tdm_rx_framer_chk #(
    parameter int STREAMS = 4,
    parameter int CHANS   = 32,
    parameter int BITS    = 8
) (
    input logic                                      clk_i,
    input logic                                      rst_ni,
    input logic                                      frame_ni,
    input logic                                      mem_we_o,
    input logic [$clog2(STREAMS)+$clog2(CHANS)-1:0]  mem_addr_o,
    input logic [$clog2(CHANS)-1:0]                  slot_chan_o,
    input logic [$clog2(BITS)-1:0]                   slot_bit_o,
    input logic                                      slot_half_o
);
    localparam int CW = $clog2(CHANS);
    localparam int PW = $clog2(BITS);
    localparam int SW = $clog2(STREAMS);
    localparam int AW = SW + CW;
    localparam logic [PW-1:0] TOP_BIT   = PW'(BITS - 1);
    localparam logic [SW-1:0] LAST_STRM = SW'(STREAMS - 1);

    logic seen_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            seen_q <= 1'b0;
        end else if (!frame_ni) begin
            seen_q <= 1'b1;
        end
    end

    // R3: a sampled frame pulse realigns to channel 0, top bit, first half
    a_r3_frame_realign: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !frame_ni |=> (slot_chan_o == '0) && (slot_bit_o == TOP_BIT) && !slot_half_o);

    // R2: the half-cell flag alternates every cycle while free running
    a_r2_half_toggle: assert property (@(posedge clk_i) disable iff (!rst_ni)
        frame_ni |=> (slot_half_o != $past(slot_half_o)));

    // R2: bit number counts down inside a channel
    a_r2_bit_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (frame_ni && slot_half_o && (slot_bit_o != '0))
        |=> (slot_bit_o == $past(slot_bit_o) - 1'b1) && (slot_chan_o == $past(slot_chan_o)));

    // R2: channel advances and wraps after its last bit
    a_r2_chan_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (frame_ni && slot_half_o && (slot_bit_o == '0))
        |=> (slot_bit_o == TOP_BIT) && (slot_chan_o == CW'($past(slot_chan_o) + 1'b1)));

    // R6: a burst starts with stream 0 right after a channel completes
    a_r6_burst_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(mem_we_o) |-> ($past(slot_half_o) && ($past(slot_bit_o) == '0)
                             && (mem_addr_o[AW-1:CW] == '0)));

    // R6: streams follow in order on the same channel
    a_r6_burst_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mem_we_o && (mem_addr_o[AW-1:CW] != LAST_STRM))
        |=> mem_we_o && (mem_addr_o[AW-1:CW] == $past(mem_addr_o[AW-1:CW]) + 1'b1)
            && (mem_addr_o[CW-1:0] == $past(mem_addr_o[CW-1:0])));

    // R6: the burst ends after the last stream
    a_r6_burst_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mem_we_o && (mem_addr_o[AW-1:CW] == LAST_STRM)) |=> !mem_we_o);

    // R7: no memory write before the first frame pulse
    a_r7_no_commit_unframed: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !seen_q |-> !mem_we_o);

endmodule

bind tdm_rx_framer tdm_rx_framer_chk #(
    .STREAMS (STREAMS),
    .CHANS   (CHANS),
    .BITS    (BITS)
) i_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .frame_ni    (frame_ni),
    .mem_we_o    (mem_we_o),
    .mem_addr_o  (mem_addr_o),
    .slot_chan_o (slot_chan_o),
    .slot_bit_o  (slot_bit_o),
    .slot_half_o (slot_half_o)
);

// File: tb/test_tdm_rx_framer.sv
module test_tdm_rx_framer;
    localparam int NS    = 4;
    localparam int NC    = 32;
    localparam int NB    = 8;
    localparam int FRAME = NC * NB * 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          frame_n = 1'b1;
    logic [NS-1:0] rx = '0;
    logic          mem_we;
    logic [6:0]    mem_addr;
    logic [7:0]    mem_wdata;
    logic [4:0]    slot_chan;
    logic [2:0]    slot_bit;
    logic          slot_half;

    tdm_rx_framer i_tdm_rx_framer (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .frame_ni    (frame_n),
        .rx_i        (rx),
        .mem_we_o    (mem_we),
        .mem_addr_o  (mem_addr),
        .mem_wdata_o (mem_wdata),
        .slot_chan_o (slot_chan),
        .slot_bit_o  (slot_bit),
        .slot_half_o (slot_half)
    );

    always #2 clk = ~clk;

    int checks = 0;
    int fails  = 0;

    // reference state derived from the requirements
    int         m;
    bit         lock;
    int         pend;
    int         es;
    int         echan;
    bit         prev_fp;
    logic [7:0] ehold [NS];
    logic [7:0] txd   [NS][NC];
    int         wcnt  [128];

    function automatic int f_chan(int c);
        return c / (NB * 2);
    endfunction

    function automatic int f_bit(int c);
        return NB - 1 - (c % (NB * 2)) / 2;
    endfunction

    function automatic int f_half(int c);
        return c % 2;
    endfunction

    task automatic check(string req, string what, int act, int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d (pos %0d)", req, what, act, exp, m);
        end
    endtask

    // Checks the current cycle, drives the next inputs, then moves to the next negedge
    task automatic step(bit fp);
        string rs;
        rs = prev_fp ? "R3" : "R2";
        check(rs, "channel", int'(slot_chan), f_chan(m));
        check(rs, "bit", int'(slot_bit), f_bit(m));
        check(rs, "half", int'(slot_half), f_half(m));
        if (!lock) begin
            check("R7", "write strobe unframed", int'(mem_we), 0);
        end else begin
            check("R6", "write strobe", int'(mem_we), (pend != 0) ? 1 : 0);
            if (pend != 0) begin
                check("R6", "address", int'(mem_addr), es * NC + echan);
                check("R4/R5", "data", int'(mem_wdata), int'(ehold[es]));
            end
        end
        if (mem_we === 1'b1) wcnt[mem_addr]++;

        frame_n = !fp;
        for (int s = 0; s < NS; s++) begin
            if (f_half(m) == 0) rx[s] = 1'($urandom);
            else                rx[s] = txd[s][f_chan(m)][f_bit(m)];
        end

        if ((m % (NB * 2)) == NB * 2 - 1 && lock) begin
            pend  = NS;
            es    = 0;
            echan = f_chan(m);
            for (int s = 0; s < NS; s++) begin
                ehold[s]      = txd[s][echan];
                txd[s][echan] = 8'($urandom);
            end
        end else if (pend != 0) begin
            pend--;
            es++;
        end
        if (fp) begin
            lock = 1'b1;
            m    = 0;
        end else begin
            m = (m + 1) % FRAME;
        end
        prev_fp = fp;
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n   = 1'b0;
        frame_n = 1'b1;
        rx      = '0;
        repeat (3) @(negedge clk);
        // R1: values held during reset
        check("R1", "reset chan", int'(slot_chan), 0);
        check("R1", "reset bit", int'(slot_bit), 7);
        check("R1", "reset half", int'(slot_half), 0);
        check("R1", "reset strobe", int'(mem_we), 0);
        rst_n   = 1'b1;
        m       = 0;
        lock    = 1'b0;
        pend    = 0;
        es      = 0;
        prev_fp = 1'b0;
    endtask

    task automatic run_regular(int n);
        for (int i = 0; i < n; i++) step(m == FRAME - 1);
    endtask

    task automatic coverage_frame();
        for (int a = 0; a < 128; a++) wcnt[a] = 0;
        run_regular(FRAME);
        for (int a = 0; a < 128; a++) check("R8", "writes per location", wcnt[a], 1);
    endtask

    initial begin
        int seed_sink;
        seed_sink = $urandom(32'h1D5EED);
        for (int s = 0; s < NS; s++)
            for (int c = 0; c < NC; c++) txd[s][c] = 8'($urandom);
        @(negedge clk);
        do_reset();
        // first cycle after release still shows the reset position (R1)
        check("R1", "chan after release", int'(slot_chan), 0);
        check("R1", "bit after release", int'(slot_bit), 7);

        // unframed free run across a counter wrap: no writes (R7)
        for (int i = 0; i < 700; i++) step(1'b0);

        // first pulse at an arbitrary position realigns (R3)
        step(1'b1);
        run_regular(2 * FRAME);
        for (int k = 0; k < 3; k++) coverage_frame();

        // mid-frame resynchronisation at random positions (R3)
        for (int k = 0; k < 6; k++) begin
            int gap;
            gap = 40 + int'($urandom % 900);
            for (int i = 0; i < gap; i++) step(1'b0);
            step(1'b1);
        end
        // pulse coinciding with a channel completion
        while ((m % 16) != 15) step(1'b0);
        step(1'b1);
        run_regular(FRAME + 37);
        coverage_frame();

        // reset mid-run, then first pulse on the edge that completes channel 31 (R7)
        do_reset();
        for (int i = 0; i < FRAME - 1; i++) step(1'b0);
        step(1'b1);
        for (int i = 0; i < 4; i++) begin
            check("R7", "no commit on first framing edge", int'(mem_we), 0);
            step(1'b0);
        end
        run_regular(FRAME);
        coverage_frame();

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule